// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the fifteen general-purpose registers (r0 to r14) of a 32-bit core that runs in one of six operating contexts. Each register number is translated to a physical storage slot according to the current mode. In fast-interrupt mode, r8 to r14 come from a private set. In the interrupt, supervisor, abort and undefined modes, only r13 and r14 are private. System mode works on the user set. Registers that are not private to a mode are shared with the user set.

Each exception mode also owns one saved-status word, which is reached through a separate port that resolves to the current mode. The block has two combinational read ports and one write port that takes effect on the clock edge. Every access follows the mode presented on the same cycle. An unsupported mode code raises an error flag. While that flag is high, reads return zero and every write is dropped.

Top module: `banked_regfile`

## Requirements
- R1: After an active-low reset on `rst_n`, every general register and every saved-status word reads as zero.
- R2: Mode codes are 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. User and system mode access the same storage for r0 to r14.
- R3: In fast-interrupt mode, r0 to r7 are the user registers, and r8 to r14 are seven registers that no other mode can reach.
- R4: In interrupt, supervisor, abort and undefined mode, r0 to r12 are the user registers. Each of these four modes has its own r13 and r14.
- R5: A write with `wr_en` high updates the addressed register at the rising clock edge. A read of the same register in that same cycle returns the previous value, and from the next cycle the read returns the new value.
- R6: The two read ports are independent. Each returns the register named by its own index in the current mode.
- R7: Any mode code other than the seven listed in R2 drives `mode_err` and `ss_err` high and makes all three read outputs zero. While the code is unsupported, both general writes and saved-status writes are ignored.
- R8: Each of the five exception modes has its own saved-status word. `ss_wr_en` writes the word of the current mode, and `ss_rd_data` shows it with no added delay.
- R9: In user or system mode, `ss_err` is high, `ss_rd_data` is zero, and a saved-status write changes no stored word.
- R10: Register index 15 is not held in this block. A read of index 15 returns zero, and a write to index 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 5 | Current operating mode code |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| ss_wr_en | input | 1 | Saved-status write enable |
| ss_wr_data | input | 32 | Saved-status write data |
| ss_rd_data | output | 32 | Saved-status word of the current mode |
| mode_err | output | 1 | Mode code is unsupported |
| ss_err | output | 1 | Current mode has no saved-status word |

## Verification
The read data, `mode_err` and `ss_err` follow the mode and index inputs within the same cycle. The bench therefore drives those inputs just after a falling edge and samples them one nanosecond later, before any rising edge. A write is due on the read ports one rising edge after it is presented. Its checks sample after the next falling edge, and the same-cycle check samples before that rising edge to confirm that the old value is still visible. A reference array indexed by owning bank and register number predicts every value across a full sweep of all seven modes and fifteen indices.

// File: rtl/brf_pkg.sv
// Package: shared sizes, mode codes and the bank type for the banked
// register file. Assumes a 15-entry architectural view (r0..r14).
package brf_pkg;

    localparam int DATA_W     = 32;
    localparam int IDX_W      = 4;
    localparam int MODE_W     = 5;
    localparam int REG_CNT    = 15;   // architectural registers held here
    localparam int FIQ_FIRST  = 8;    // first register private to fast interrupt
    localparam int PRIV_FIRST = 13;   // first register private to the other modes
    localparam int PRIV_MODES = 4;    // interrupt, supervisor, abort, undefined

    localparam int FIQ_CNT    = REG_CNT - FIQ_FIRST;
    localparam int PRIV_CNT   = REG_CNT - PRIV_FIRST;
    localparam int SLOT_CNT   = REG_CNT + FIQ_CNT + PRIV_MODES * PRIV_CNT;
    localparam int SLOT_W     = $clog2(SLOT_CNT);
    localparam int SS_CNT     = 1 + PRIV_MODES;
    localparam int SS_W       = $clog2(SS_CNT);

    localparam logic [MODE_W-1:0] MC_USER = 5'h10;
    localparam logic [MODE_W-1:0] MC_FAST = 5'h11;
    localparam logic [MODE_W-1:0] MC_INTR = 5'h12;
    localparam logic [MODE_W-1:0] MC_SUPV = 5'h13;
    localparam logic [MODE_W-1:0] MC_ABRT = 5'h17;
    localparam logic [MODE_W-1:0] MC_UNDF = 5'h1B;
    localparam logic [MODE_W-1:0] MC_SYST = 5'h1F;

    // Bank numbering: BK_INTR onward must stay contiguous (slot arithmetic).
    typedef enum logic [2:0] {
        BK_USER = 3'd0,
        BK_FAST = 3'd1,
        BK_INTR = 3'd2,
        BK_SUPV = 3'd3,
        BK_ABRT = 3'd4,
        BK_UNDF = 3'd5
    } bank_e;

endpackage

// File: rtl/brf_mode_dec.sv
// Module: brf_mode_dec
// Turns a mode code into a bank selector and a supported flag.
// Assumes the seven codes in brf_pkg; any other code is unsupported and
// yields BK_USER with valid low.
module brf_mode_dec
    import brf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o,
    output logic              valid_o
);

    // Decode the mode code into its bank.
    always_comb begin
        bank_o  = BK_USER;
        valid_o = 1'b1;
        unique case (mode_i)
            MC_USER, MC_SYST: bank_o = BK_USER;
            MC_FAST:          bank_o = BK_FAST;
            MC_INTR:          bank_o = BK_INTR;
            MC_SUPV:          bank_o = BK_SUPV;
            MC_ABRT:          bank_o = BK_ABRT;
            MC_UNDF:          bank_o = BK_UNDF;
            default:          valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/brf_slot_map.sv
// Module: brf_slot_map
// Maps (bank, register number) to a physical slot. Slot layout:
// user set first, then the fast-interrupt set, then two-entry sets for
// the remaining exception modes in bank order. hit_o is low for numbers
// at or above REG_CNT.
module brf_slot_map
    import brf_pkg::*;
(
    input  bank_e             bank_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              hit_o
);

    localparam int FIQ_BASE  = REG_CNT;
    localparam int PRIV_BASE = REG_CNT + FIQ_CNT;

    // Choose the shared or the private slot for this register number.
    always_comb begin
        slot_o = '0;
        hit_o  = 1'b1;
        if (int'(idx_i) >= REG_CNT) begin
            hit_o = 1'b0;
        end else if (bank_i == BK_FAST && int'(idx_i) >= FIQ_FIRST) begin
            slot_o = SLOT_W'(FIQ_BASE + int'(idx_i) - FIQ_FIRST);
        end else if (bank_i >= BK_INTR && int'(idx_i) >= PRIV_FIRST) begin
            slot_o = SLOT_W'(PRIV_BASE
                             + (int'(bank_i) - int'(BK_INTR)) * PRIV_CNT
                             + int'(idx_i) - PRIV_FIRST);
        end else begin
            slot_o = SLOT_W'(idx_i);
        end
    end

endmodule

// File: rtl/brf_gpr_store.sv
// Module: brf_gpr_store
// Flat physical storage for all general register slots: one write port,
// two asynchronous read ports. Reads see the value before a same-cycle
// write. Assumes slot numbers below SLOT_CNT when the enables are set.
module brf_gpr_store
    import brf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] wslot_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ra_en_i,
    input  logic [SLOT_W-1:0] ra_slot_i,
    output logic [DATA_W-1:0] ra_data_o,
    input  logic              rb_en_i,
    input  logic [SLOT_W-1:0] rb_slot_i,
    output logic [DATA_W-1:0] rb_data_o
);

    logic [DATA_W-1:0] mem_q [SLOT_CNT];

    // Per-slot registers: cleared on reset, loaded when addressed.
    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[s] <= '0;
            else if (we_i && wslot_i == SLOT_W'(s))
                mem_q[s] <= wdata_i;
        end
    end

    // Read port A: selected slot or zero when disabled.
    always_comb begin
        ra_data_o = '0;
        if (ra_en_i && int'(ra_slot_i) < SLOT_CNT)
            ra_data_o = mem_q[ra_slot_i];
    end

    // Read port B: selected slot or zero when disabled.
    always_comb begin
        rb_data_o = '0;
        if (rb_en_i && int'(rb_slot_i) < SLOT_CNT)
            rb_data_o = mem_q[rb_slot_i];
    end

endmodule

// File: rtl/brf_status_store.sv
// Module: brf_status_store
// One saved-status word per exception mode, indexed by bank number minus
// one. Caller gates enables with mode validity.
module brf_status_store
    import brf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [SS_W-1:0]   sel_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] word_q [SS_CNT];

    // Per-mode status words: cleared on reset, loaded when selected.
    for (genvar m = 0; m < SS_CNT; m++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[m] <= '0;
            else if (en_i && we_i && sel_i == SS_W'(m))
                word_q[m] <= wdata_i;
        end
    end

    // Read the selected word, or zero when no word applies.
    always_comb begin
        rdata_o = '0;
        if (en_i && int'(sel_i) < SS_CNT)
            rdata_o = word_q[sel_i];
    end

endmodule

// File: rtl/banked_regfile.sv
// Module: banked_regfile (top)
// Mode-banked register file: decodes the mode, maps the write index and
// both read indices to physical slots, and selects the saved-status word
// of the current mode. Assumes mode_i is stable around each rising edge.
module banked_regfile
    import brf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [4:0]           mode_i,
    input  logic [3:0]           rd_a_idx,
    output logic [31:0]          rd_a_data,
    input  logic [3:0]           rd_b_idx,
    output logic [31:0]          rd_b_data,
    input  logic                 wr_en,
    input  logic [3:0]           wr_idx,
    input  logic [31:0]          wr_data,
    input  logic                 ss_wr_en,
    input  logic [31:0]          ss_wr_data,
    output logic [31:0]          ss_rd_data,
    output logic                 mode_err,
    output logic                 ss_err
);

    localparam int PORTS = 3;   // 0: write, 1: read A, 2: read B

    bank_e             bank;
    logic              mode_ok;
    logic [IDX_W-1:0]  port_idx  [PORTS];
    logic [SLOT_W-1:0] port_slot [PORTS];
    logic              port_hit  [PORTS];
    logic              ss_ok;
    logic [SS_W-1:0]   ss_sel;

    brf_mode_dec u_dec (
        .mode_i  (mode_i),
        .bank_o  (bank),
        .valid_o (mode_ok)
    );

    // Gather the three register indices for the mapper array.
    always_comb begin
        port_idx[0] = wr_idx;
        port_idx[1] = rd_a_idx;
        port_idx[2] = rd_b_idx;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_map
        brf_slot_map u_map (
            .bank_i (bank),
            .idx_i  (port_idx[p]),
            .slot_o (port_slot[p]),
            .hit_o  (port_hit[p])
        );
    end

    brf_gpr_store u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en && mode_ok && port_hit[0]),
        .wslot_i   (port_slot[0]),
        .wdata_i   (wr_data),
        .ra_en_i   (mode_ok && port_hit[1]),
        .ra_slot_i (port_slot[1]),
        .ra_data_o (rd_a_data),
        .rb_en_i   (mode_ok && port_hit[2]),
        .rb_slot_i (port_slot[2]),
        .rb_data_o (rd_b_data)
    );

    // Status word exists only for a supported exception mode.
    always_comb begin
        ss_ok  = mode_ok && (bank != BK_USER);
        ss_sel = ss_ok ? SS_W'(int'(bank) - 1) : '0;
    end

    brf_status_store u_ss (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (ss_ok),
        .sel_i   (ss_sel),
        .we_i    (ss_wr_en),
        .wdata_i (ss_wr_data),
        .rdata_o (ss_rd_data)
    );

    // Error flags presented at the ports.
    always_comb begin
        mode_err = !mode_ok;
        ss_err   = !ss_ok;
    end

endmodule

// File: rtl/brf_checker.sv
// Module: brf_checker
// Port-level properties of banked_regfile, attached by bind below.
module brf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  mode_i,
    input logic [3:0]  rd_a_idx,
    input logic [31:0] rd_a_data,
    input logic [31:0] rd_b_data,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        ss_wr_en,
    input logic [31:0] ss_wr_data,
    input logic [31:0] ss_rd_data,
    input logic        mode_err,
    input logic        ss_err
);

    // R5
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_err && wr_idx != 4'hF && wr_idx == rd_a_idx)
        ##1 ($stable(mode_i) && $stable(rd_a_idx))
        |-> rd_a_data == $past(wr_data));

    // R7
    bad_mode_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (rd_a_data == '0 && rd_b_data == '0 && ss_rd_data == '0));

    // R7
    bad_mode_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> ss_err);

    // R8
    ss_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_wr_en && !ss_err) ##1 $stable(mode_i)
        |-> ss_rd_data == $past(ss_wr_data));

    // R9
    no_ss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_err |-> ss_rd_data == '0);

    // R10
    idx15_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_idx == 4'hF |-> rd_a_data == '0);

endmodule

bind banked_regfile brf_checker u_brf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_data  (rd_b_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .ss_wr_en   (ss_wr_en),
    .ss_wr_data (ss_wr_data),
    .ss_rd_data (ss_rd_data),
    .mode_err   (mode_err),
    .ss_err     (ss_err)
);

// File: tb/sim_banked_regfile.sv
// Bench: sweeps all supported modes and register numbers against an
// arithmetic reference keyed by owning bank and register number.
module sim_banked_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'h10;
    logic [3:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        ss_wr_en = 1'b0;
    logic [31:0] ss_wr_data = '0;
    logic [31:0] ss_rd_data;
    logic        mode_err;
    logic        ss_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] ref_gpr [6*16];
    logic [31:0] ref_ss  [8];
    logic [4:0]  modes   [7];

    always #5 clk = ~clk;

    banked_regfile u0 (.*);

    // Bank number of a mode code; 7 marks unsupported.
    function automatic int bank_of(logic [4:0] m);
        case (m)
            5'h10, 5'h1F: return 0;
            5'h11: return 1;
            5'h12: return 2;
            5'h13: return 3;
            5'h17: return 4;
            5'h1B: return 5;
            default: return 7;
        endcase
    endfunction

    // Bank that owns register i when running in mode m.
    function automatic int owner(logic [4:0] m, int i);
        int b = bank_of(m);
        if (b == 1 && i >= 8) return 1;
        if (b >= 2 && b <= 5 && i >= 13) return b;
        return 0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present mode and read indices, sample combinational outputs.
    task automatic look(logic [4:0] m, int ia, int ib);
        @(negedge clk);
        mode_i = m; rd_a_idx = 4'(ia); rd_b_idx = 4'(ib);
        #1;
    endtask

    task automatic wr_reg(logic [4:0] m, int i, logic [31:0] d);
        @(negedge clk);
        mode_i = m; wr_idx = 4'(i); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (bank_of(m) != 7 && i < 15) ref_gpr[owner(m, i)*16 + i] = d;
    endtask

    task automatic wr_ss(logic [4:0] m, logic [31:0] d);
        @(negedge clk);
        mode_i = m; ss_wr_data = d; ss_wr_en = 1'b1;
        @(negedge clk);
        ss_wr_en = 1'b0;
        if (bank_of(m) >= 1 && bank_of(m) <= 5) ref_ss[bank_of(m)] = d;
    endtask

    function automatic string tag_for(logic [4:0] m);
        int b = bank_of(m);
        if (b == 0) return "R2";
        if (b == 1) return "R3";
        return "R4";
    endfunction

    initial begin
        modes[0] = 5'h10; modes[1] = 5'h11; modes[2] = 5'h12; modes[3] = 5'h13;
        modes[4] = 5'h17; modes[5] = 5'h1B; modes[6] = 5'h1F;
        for (int k = 0; k < 96; k++) ref_gpr[k] = '0;
        for (int k = 0; k < 8; k++) ref_ss[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset
        for (int mi = 0; mi < 7; mi++) begin
            for (int i = 0; i < 15; i++) begin
                look(modes[mi], i, 14 - i);
                check("R1", rd_a_data, 32'h0);
                check("R1", rd_b_data, 32'h0);
            end
            check("R1", ss_rd_data, 32'h0);
            check("R2", {31'h0, mode_err}, 32'h0);
        end

        // Fill every index in every mode with a distinct value.
        for (int mi = 0; mi < 7; mi++)
            for (int i = 0; i < 15; i++)
                wr_reg(modes[mi], i, {8'hC3, 3'(mi), modes[mi], 4'(i), 12'h5A0 + 12'(mi*16 + i)});

        // R2 R3 R4 R6: full read sweep on both ports
        for (int mi = 0; mi < 7; mi++)
            for (int i = 0; i < 15; i++) begin
                look(modes[mi], i, 14 - i);
                check(tag_for(modes[mi]), rd_a_data, ref_gpr[owner(modes[mi], i)*16 + i]);
                check("R6", rd_b_data, ref_gpr[owner(modes[mi], 14 - i)*16 + 14 - i]);
            end

        // R10: index 15 reads zero, write to it changes nothing
        wr_reg(5'h10, 15, 32'hDEAD_BEEF);
        for (int i = 0; i < 16; i++) begin
            look(5'h10, 15, i);
            check("R10", rd_a_data, 32'h0);
            check("R10", rd_b_data, (i == 15) ? 32'h0 : ref_gpr[i]);
        end

        // R5: same-cycle write returns old value, new value next cycle
        @(negedge clk);
        mode_i = 5'h13; rd_a_idx = 4'd13; wr_idx = 4'd13;
        wr_data = 32'h1357_9BDF; wr_en = 1'b1;
        #1;
        check("R5", rd_a_data, ref_gpr[3*16 + 13]);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        ref_gpr[3*16 + 13] = 32'h1357_9BDF;
        check("R5", rd_a_data, 32'h1357_9BDF);
        look(5'h12, 13, 13);
        check("R5", rd_a_data, ref_gpr[2*16 + 13]);

        // R8: saved-status word per exception mode
        for (int mi = 1; mi < 6; mi++) wr_ss(modes[mi], 32'hA000_0000 + 32'(mi * 257));
        for (int mi = 1; mi < 6; mi++) begin
            look(modes[mi], 0, 0);
            check("R8", ss_rd_data, ref_ss[bank_of(modes[mi])]);
            check("R8", {31'h0, ss_err}, 32'h0);
        end

        // R9: user/system have no saved-status word
        wr_ss(5'h10, 32'hFFFF_0001);
        wr_ss(5'h1F, 32'hFFFF_0002);
        look(5'h10, 0, 0);
        check("R9", {31'h0, ss_err}, 32'h1);
        check("R9", ss_rd_data, 32'h0);
        look(5'h1F, 0, 0);
        check("R9", {31'h0, ss_err}, 32'h1);
        for (int mi = 1; mi < 6; mi++) begin
            look(modes[mi], 0, 0);
            check("R9", ss_rd_data, ref_ss[bank_of(modes[mi])]);
        end

        // R7: unsupported codes flag errors, read zero, drop writes
        begin
            logic [4:0] bad [6];
            bad[0] = 5'h00; bad[1] = 5'h14; bad[2] = 5'h1A;
            bad[3] = 5'h1E; bad[4] = 5'h15; bad[5] = 5'h0F;
            for (int b = 0; b < 6; b++) begin
                wr_reg(bad[b], 3, 32'hBAD0_0000 + 32'(b));
                wr_reg(bad[b], 14, 32'hBAD1_0000 + 32'(b));
                wr_ss(bad[b], 32'hBAD2_0000 + 32'(b));
                look(bad[b], 3, 14);
                check("R7", {31'h0, mode_err}, 32'h1);
                check("R7", {31'h0, ss_err}, 32'h1);
                check("R7", rd_a_data, 32'h0);
                check("R7", rd_b_data, 32'h0);
                check("R7", ss_rd_data, 32'h0);
            end
            for (int mi = 0; mi < 7; mi++) begin
                look(modes[mi], 3, 14);
                check("R7", rd_a_data, ref_gpr[3]);
                check("R7", rd_b_data, ref_gpr[owner(modes[mi], 14)*16 + 14]);
                check("R7", ss_rd_data, ref_ss[bank_of(modes[mi])]);
            end
        end

        // R1: reset again clears stored state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int mi = 0; mi < 7; mi++) begin
            look(modes[mi], 14, 8);
            check("R1", rd_a_data, 32'h0);
            check("R1", rd_b_data, 32'h0);
            check("R1", ss_rd_data, 32'h0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule